// File: doc/BRIEF.md
# SDRAM Command Spacing Guard

This block sits beside an SDRAM command scheduler and answers one question each clock cycle: may the command now proposed be sent to the memory? The scheduler presents a request made of a valid flag, a command code and a bank number. In the same cycle the guard returns a grant. A granted command is taken as issued on that clock edge. It reloads the timers that govern what may follow it, on its own bank or across all banks.

The minimum spacings come from one 32-bit configuration word that holds seven packed fields. Each field stores the needed gap in clock cycles minus one. Every timer is a down-counter that reloads with the field value when its command is granted. A request is allowed only when every counter that applies to it has reached zero.

Four banks are tracked by default. Each bank has its own counters for activate-to-access, activate-to-precharge, activate-to-activate, activate-spacing toward other banks, write recovery and precharge. One global counter holds the refresh-to-refresh spacing.

Top module: `sdram_timing_guard`

## Requirements
- R1: The configuration word resets to 0x42215810. The field layout is: refresh spacing in bits 31:27, precharge spacing in 26:24, activate-to-access in 22:20, write recovery in 18:16, activate-to-precharge in 15:12, same-bank activate spacing in 11:8, and other-bank activate spacing in 6:4. Bits 23, 19, 7 and 3:0 always read back as zero, whatever value was written to them.
- R2: After reset every timer has expired, so any legal command to any bank is granted in the first request cycle.
- R3: After a granted refresh, another refresh is granted no earlier than refresh-field+1 cycles later.
- R4: After a granted precharge of bank b, an activate of bank b waits precharge-field+1 cycles. A refresh waits precharge-field+1 cycles after a precharge of any bank.
- R5: After a granted activate of bank b, a read or write of bank b waits activate-to-access-field+1 cycles.
- R6: A precharge of bank b waits activate-to-precharge-field+1 cycles after the activate of bank b. It also waits write-recovery-field+1 cycles after the last write to bank b.
- R7: An activate of bank b waits same-bank-activate-field+1 cycles after an activate of bank b. It waits other-bank-activate-field+1 cycles after an activate of any other bank.
- R8: Any command pair not named in R3 to R7 is granted in the cycle right after the first command. This includes accesses and activates that follow a command on a different bank.
- R9: Command codes are 1 for activate, 2 for read, 3 for write, 4 for precharge and 5 for refresh. Codes 0, 6 and 7 are never granted. When valid is low, no grant is given. A request that is not granted reloads no timer.
- R10: A new configuration word applies only to commands granted after it is written. A timer that is already counting keeps the value it was loaded with.
- R11: The grant is combinational from the present request and timer state. A spacing of N+1 cycles means that a request held from the cycle after the first command is granted exactly N+1 cycles after that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the timing word |
| cfg_wr_data | input | 32 | New timing word |
| cfg_rd_data | output | 32 | Stored timing word, with reserved bits read as zero |
| req_valid | input | 1 | A command is proposed this cycle |
| req_cmd | input | 3 | Proposed command code |
| req_bank | input | 2 | Target bank of the proposed command |
| grant | output | 1 | Proposed command may issue; it counts as issued at the next edge |

## Verification
The bench builds the guard with its default of four banks. This keeps all bank pairs small enough to sweep: every ordered pair of the five commands, on the same bank and on a neighbouring bank, from every starting bank. The sweep runs under four timing words: the reset word, all zeros, all ones, and a word in which every field holds a different value. The last of these exposes any swapped or misread field. Each measured gap is compared with one plus the largest field that applies, computed from the word by shifts and masks.

// File: rtl/sdtg_pkg.sv
package sdtg_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } cmd_e;

    // Field widths and positions inside the timing word.
    localparam int RFC_W   = 5;
    localparam int RP_W    = 3;
    localparam int RCD_W   = 3;
    localparam int WR_W    = 3;
    localparam int RAS_W   = 4;
    localparam int RC_W    = 4;
    localparam int RRD_W   = 3;

    localparam int RFC_LSB = 27;
    localparam int RP_LSB  = 24;
    localparam int RCD_LSB = 20;
    localparam int WR_LSB  = 16;
    localparam int RAS_LSB = 12;
    localparam int RC_LSB  = 8;
    localparam int RRD_LSB = 4;

    localparam logic [31:0] CFG_RESET = 32'h4221_5810;
    localparam logic [31:0] CFG_RSV   = 32'h0088_008F;

    typedef struct packed {
        logic [RFC_W-1:0] rfc;
        logic [RP_W-1:0]  rp;
        logic [RCD_W-1:0] rcd;
        logic [WR_W-1:0]  wr;
        logic [RAS_W-1:0] ras;
        logic [RC_W-1:0]  rc;
        logic [RRD_W-1:0] rrd;
    } tcfg_t;

endpackage

// File: rtl/sdtg_countdown.sv
module sdtg_countdown #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdtg_cfg_reg.sv
module sdtg_cfg_reg
    import sdtg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] word,
    output tcfg_t       tcfg
);

    logic [31:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= CFG_RESET;
        end else if (wr_en) begin
            word_q <= wr_data & ~CFG_RSV;
        end
    end

    assign word     = word_q;
    assign tcfg.rfc = word_q[RFC_LSB +: RFC_W];
    assign tcfg.rp  = word_q[RP_LSB  +: RP_W];
    assign tcfg.rcd = word_q[RCD_LSB +: RCD_W];
    assign tcfg.wr  = word_q[WR_LSB  +: WR_W];
    assign tcfg.ras = word_q[RAS_LSB +: RAS_W];
    assign tcfg.rc  = word_q[RC_LSB  +: RC_W];
    assign tcfg.rrd = word_q[RRD_LSB +: RRD_W];

endmodule

// File: rtl/sdtg_bank_timers.sv
module sdtg_bank_timers
    import sdtg_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 grant,
    input  logic [2:0]           cmd,
    input  logic [BANK_W-1:0]    bank,
    input  logic [RP_W-1:0]      f_rp,
    input  logic [RCD_W-1:0]     f_rcd,
    input  logic [WR_W-1:0]      f_wr,
    input  logic [RAS_W-1:0]     f_ras,
    input  logic [RC_W-1:0]      f_rc,
    input  logic [RRD_W-1:0]     f_rrd,
    output logic [NUM_BANKS-1:0] rcd_ok,
    output logic [NUM_BANKS-1:0] ras_ok,
    output logic [NUM_BANKS-1:0] rc_ok,
    output logic [NUM_BANKS-1:0] rrd_ok,
    output logic [NUM_BANKS-1:0] wr_ok,
    output logic [NUM_BANKS-1:0] rp_ok
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        logic act_g;
        logic wr_g;
        logic pre_g;

        assign hit   = grant && (bank == BANK_W'(b));
        assign act_g = hit && (cmd == CMD_ACT);
        assign wr_g  = hit && (cmd == CMD_WR);
        assign pre_g = hit && (cmd == CMD_PRE);

        sdtg_countdown #(.W(RCD_W)) u_rcd (
            .clk(clk), .rst_n(rst_n), .load(act_g), .load_val(f_rcd), .expired(rcd_ok[b])
        );
        sdtg_countdown #(.W(RAS_W)) u_ras (
            .clk(clk), .rst_n(rst_n), .load(act_g), .load_val(f_ras), .expired(ras_ok[b])
        );
        sdtg_countdown #(.W(RC_W)) u_rc (
            .clk(clk), .rst_n(rst_n), .load(act_g), .load_val(f_rc), .expired(rc_ok[b])
        );
        sdtg_countdown #(.W(RRD_W)) u_rrd (
            .clk(clk), .rst_n(rst_n), .load(act_g), .load_val(f_rrd), .expired(rrd_ok[b])
        );
        sdtg_countdown #(.W(WR_W)) u_wr (
            .clk(clk), .rst_n(rst_n), .load(wr_g), .load_val(f_wr), .expired(wr_ok[b])
        );
        sdtg_countdown #(.W(RP_W)) u_rp (
            .clk(clk), .rst_n(rst_n), .load(pre_g), .load_val(f_rp), .expired(rp_ok[b])
        );
    end

endmodule

// File: rtl/sdram_timing_guard.sv
module sdram_timing_guard
    import sdtg_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [31:0]       cfg_wr_data,
    output logic [31:0]       cfg_rd_data,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    output logic              grant
);

    tcfg_t                tcfg;
    logic [NUM_BANKS-1:0] rcd_ok;
    logic [NUM_BANKS-1:0] ras_ok;
    logic [NUM_BANKS-1:0] rc_ok;
    logic [NUM_BANKS-1:0] rrd_ok;
    logic [NUM_BANKS-1:0] wr_ok;
    logic [NUM_BANKS-1:0] rp_ok;
    logic [NUM_BANKS-1:0] own_bank;
    logic                 rfc_ok;
    logic                 legal;

    sdtg_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .word    (cfg_rd_data),
        .tcfg    (tcfg)
    );

    sdtg_bank_timers #(.NUM_BANKS(NUM_BANKS)) u_banks (
        .clk    (clk),
        .rst_n  (rst_n),
        .grant  (grant),
        .cmd    (req_cmd),
        .bank   (req_bank),
        .f_rp   (tcfg.rp),
        .f_rcd  (tcfg.rcd),
        .f_wr   (tcfg.wr),
        .f_ras  (tcfg.ras),
        .f_rc   (tcfg.rc),
        .f_rrd  (tcfg.rrd),
        .rcd_ok (rcd_ok),
        .ras_ok (ras_ok),
        .rc_ok  (rc_ok),
        .rrd_ok (rrd_ok),
        .wr_ok  (wr_ok),
        .rp_ok  (rp_ok)
    );

    sdtg_countdown #(.W(RFC_W)) u_rfc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (grant && (req_cmd == CMD_REF)),
        .load_val (tcfg.rfc),
        .expired  (rfc_ok)
    );

    // One-hot of the requested bank, used to exclude it from the
    // other-bank activate spacing.
    always_comb begin
        own_bank           = '0;
        own_bank[req_bank] = 1'b1;
    end

    always_comb begin
        legal = 1'b0;
        unique case (req_cmd)
            CMD_ACT:        legal = rc_ok[req_bank] && rp_ok[req_bank]
                                    && (&(rrd_ok | own_bank));
            CMD_RD, CMD_WR: legal = rcd_ok[req_bank];
            CMD_PRE:        legal = ras_ok[req_bank] && wr_ok[req_bank];
            CMD_REF:        legal = rfc_ok && (&rp_ok);
            default:        legal = 1'b0;
        endcase
    end

    assign grant = req_valid && legal;

endmodule

// File: rtl/sdtg_chk.sv
module sdtg_chk
    import sdtg_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       cfg_rd_data,
    input logic              req_valid,
    input logic [2:0]        req_cmd,
    input logic [BANK_W-1:0] req_bank,
    input logic              grant
);

    logic g_act, g_wr, g_pre, g_ref, g_acc;
    assign g_act = grant && (req_cmd == CMD_ACT);
    assign g_wr  = grant && (req_cmd == CMD_WR);
    assign g_pre = grant && (req_cmd == CMD_PRE);
    assign g_ref = grant && (req_cmd == CMD_REF);
    assign g_acc = grant && ((req_cmd == CMD_RD) || (req_cmd == CMD_WR));

    // R1
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data & CFG_RSV) == 32'h0);

    // R9
    no_grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !grant);

    // R3
    ref_ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (g_ref && (cfg_rd_data[RFC_LSB +: RFC_W] != '0)) |=> !g_ref);

    // R4
    pre_ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (g_pre && (cfg_rd_data[RP_LSB +: RP_W] != '0)) |=> !g_ref);

    // R5
    act_acc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (g_act && (cfg_rd_data[RCD_LSB +: RCD_W] != '0))
        |=> !(g_acc && (req_bank == $past(req_bank))));

    // R6
    wr_pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (g_wr && (cfg_rd_data[WR_LSB +: WR_W] != '0))
        |=> !(g_pre && (req_bank == $past(req_bank))));

    // R7
    act_act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (g_act && (cfg_rd_data[RRD_LSB +: RRD_W] != '0)
               && (cfg_rd_data[RC_LSB +: RC_W] != '0)) |=> !g_act);

endmodule

bind sdram_timing_guard sdtg_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rd_data (cfg_rd_data),
    .req_valid   (req_valid),
    .req_cmd     (req_cmd),
    .req_bank    (req_bank),
    .grant       (grant)
);

// File: tb/sdram_timing_guard_tb.sv
module sdram_timing_guard_tb_top;

    localparam logic [2:0] C_ACT = 3'd1;
    localparam logic [2:0] C_RD  = 3'd2;
    localparam logic [2:0] C_WR  = 3'd3;
    localparam logic [2:0] C_PRE = 3'd4;
    localparam logic [2:0] C_REF = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        req_valid = 1'b0;
    logic [2:0]  req_cmd = '0;
    logic [1:0]  req_bank = '0;
    logic        grant;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sdram_timing_guard dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_bank(req_bank), .grant(grant)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // One cycle: drive at the falling edge, let the grant settle.
    task automatic drive(input bit v, input logic [2:0] c, input logic [1:0] b,
                         input bit we, input logic [31:0] wd);
        @(negedge clk);
        req_valid   = v;
        req_cmd     = c;
        req_bank    = b;
        cfg_wr_en   = we;
        cfg_wr_data = wd;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 3'd0, 2'd0, 1'b0, 32'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle();
        idle();
        rst_n = 1'b1;
    endtask

    function automatic int fld(input logic [31:0] w, input int lsb, input int width);
        return int'((w >> lsb) & ((32'h1 << width) - 1));
    endfunction

    function automatic int exp_gap(input logic [31:0] w, input logic [2:0] a,
                                   input logic [2:0] b, input bit same);
        if (a == C_REF && b == C_REF)                  return fld(w, 27, 5) + 1;
        if (a == C_PRE && ((b == C_ACT && same) || b == C_REF))
                                                       return fld(w, 24, 3) + 1;
        if (a == C_ACT && same && (b == C_RD || b == C_WR))
                                                       return fld(w, 20, 3) + 1;
        if (a == C_ACT && same && b == C_PRE)          return fld(w, 12, 4) + 1;
        if (a == C_ACT && b == C_ACT)                  return same ? fld(w, 8, 4) + 1
                                                                   : fld(w, 4, 3) + 1;
        if (a == C_WR && same && b == C_PRE)           return fld(w, 16, 3) + 1;
        return 1;
    endfunction

    function automatic string req_of(input logic [2:0] a, input logic [2:0] b, input bit same);
        if (a == C_REF && b == C_REF)                        return "R3";
        if (a == C_PRE && ((b == C_ACT && same) || b == C_REF)) return "R4";
        if (a == C_ACT && same && (b == C_RD || b == C_WR))  return "R5";
        if ((a == C_ACT || a == C_WR) && same && b == C_PRE) return "R6";
        if (a == C_ACT && b == C_ACT)                        return "R7";
        return "R8";
    endfunction

    task automatic pair_trial(input logic [31:0] w, input logic [2:0] a, input logic [1:0] ba,
                              input logic [2:0] b, input logic [1:0] bb);
        int gap;
        int e;
        do_reset();
        drive(1'b0, 3'd0, 2'd0, 1'b1, w);
        drive(1'b1, a, ba, 1'b0, 32'h0);
        // R2: all timers expired after reset
        check(grant == 1'b1, "R2", $sformatf("first cmd %0d bank %0d", a, ba), grant, 1);
        gap = 0;
        for (int k = 1; k <= 40; k++) begin
            drive(1'b1, b, bb, 1'b0, 32'h0);
            if (grant) begin
                gap = k;
                break;
            end
        end
        idle();
        e = exp_gap(w, a, b, ba == bb);
        // R11: gap measured in cycles from the first grant
        check(gap == e, req_of(a, b, ba == bb),
              $sformatf("gap cfg=%h %0d/b%0d -> %0d/b%0d", w, a, ba, b, bb), gap, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        logic [31:0] cfgs [4];
        int gap;
        cfgs[0] = 32'h4221_5810;
        cfgs[1] = 32'h0000_0000;
        cfgs[2] = 32'h5B45_6720;
        cfgs[3] = 32'hFFFF_FFFF;

        // R1: reset value and reserved bits
        do_reset();
        check(cfg_rd_data == 32'h4221_5810, "R1", "reset word", cfg_rd_data, 32'h4221_5810);
        drive(1'b0, 3'd0, 2'd0, 1'b1, 32'hFFFF_FFFF);
        idle();
        check(cfg_rd_data == 32'hFF77_FF70, "R1", "all-ones write", cfg_rd_data, 32'hFF77_FF70);
        drive(1'b0, 3'd0, 2'd0, 1'b1, 32'h0088_008F);
        idle();
        check(cfg_rd_data == 32'h0, "R1", "reserved-only write", cfg_rd_data, 0);

        // R9: invalid codes and low valid are never granted and load nothing
        do_reset();
        drive(1'b0, C_ACT, 2'd0, 1'b0, 32'h0);
        check(grant == 1'b0, "R9", "valid low", grant, 0);
        drive(1'b1, 3'd0, 2'd0, 1'b0, 32'h0);
        check(grant == 1'b0, "R9", "code 0", grant, 0);
        drive(1'b1, 3'd6, 2'd0, 1'b0, 32'h0);
        check(grant == 1'b0, "R9", "code 6", grant, 0);
        drive(1'b1, 3'd7, 2'd0, 1'b0, 32'h0);
        check(grant == 1'b0, "R9", "code 7", grant, 0);
        drive(1'b1, C_ACT, 2'd0, 1'b0, 32'h0);
        check(grant == 1'b1, "R9", "activate after ignored requests", grant, 1);
        idle();
        do_reset();
        drive(1'b0, C_REF, 2'd0, 1'b0, 32'h0);
        drive(1'b1, C_REF, 2'd0, 1'b0, 32'h0);
        check(grant == 1'b1, "R9", "refresh after unvalidated refresh", grant, 1);
        idle();

        // R10: running timer keeps its value after a config change
        do_reset();
        drive(1'b1, C_ACT, 2'd1, 1'b0, 32'h0);
        drive(1'b0, 3'd0, 2'd0, 1'b1, 32'h0);
        gap = 0;
        for (int k = 2; k <= 40; k++) begin
            drive(1'b1, C_ACT, 2'd1, 1'b0, 32'h0);
            if (grant) begin
                gap = k;
                break;
            end
        end
        check(gap == 9, "R10", "old same-bank spacing kept", gap, 9);
        gap = 0;
        for (int k = 1; k <= 40; k++) begin
            drive(1'b1, C_ACT, 2'd1, 1'b0, 32'h0);
            if (grant) begin
                gap = k;
                break;
            end
        end
        check(gap == 1, "R10", "new spacing after change", gap, 1);
        idle();

        // R3..R8: sweep of command pairs, banks and timing words
        for (int ci = 0; ci < 4; ci++)
            for (int a = 1; a <= 5; a++)
                for (int b = 1; b <= 5; b++)
                    for (int ba = 0; ba < 4; ba++)
                        for (int d = 0; d < 2; d++)
                            pair_trial(cfgs[ci], 3'(a), 2'(ba), 3'(b),
                                       (d == 0) ? 2'(ba) : 2'(ba + 1));

        finish_up();
    end

endmodule